// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block chooses one of ten interrupt vectors to present to a CPU and keeps track of nested service. Each vector has a pending flag, an enable bit and a one-bit level select. The level select picks between a high and a low priority level. Together these give three service levels: top, high and low. The block drives a registered interrupt request together with the address of the chosen vector. It also reports the level that is currently in service.

The CPU acknowledges the vector it was offered. On acknowledge, the current level is saved on a small stack and the vector's level becomes the new current level. A return pulse restores the saved level. A request is accepted only when its level is strictly above the level currently in service, so an interrupt can only be pre-empted by a higher level.

Top module: `irq_level_ctrl`

## Requirements
- R1: The vector at zero-based index v is presented as address 0x03 + 8*v on vec_addr_o. The address is valid while irq_o is high.
- R2: When hi_i[v] is 1, indices 0 and 1 take the top level and indices 2 to 9 take the high level. When hi_i[v] is 0, the vector takes the low level. A top-level vector is accepted while the high level is in service.
- R3: When eligible vectors request at different levels, the vector with the higher level is presented, whatever the indices.
- R4: When eligible vectors request at the same level, the vector with the lowest index is presented.
- R5: A vector is not presented if its enable bit is 0, or if its level is equal to or below cur_lvl_o. A waiting vector is presented once the service level drops below its level.
- R6: An acknowledge while irq_o is high pushes the current level onto the stack and sets cur_lvl_o to the presented vector's level. irq_o is low in the cycle after the acknowledge.
- R7: A return pulse sets cur_lvl_o to the most recently pushed level. A return pulse with an empty stack leaves cur_lvl_o unchanged.
- R8: For an edge-type vector (edge_i[v]=1), a high req_i[v] sets a sticky pending flag. An accepted acknowledge of that vector clears the flag. If req_i[v] is high in the same cycle as the acknowledge, the flag stays set. For a level-type vector (edge_i[v]=0), the pending flag follows req_i[v] and an acknowledge does not clear it.
- R9: Pending flags capture req_i at a clock edge. irq_o and vec_addr_o follow the pending state at the next edge, so a single-cycle req_i pulse raises irq_o two edges after it is applied.
- R10: After reset, irq_o is 0, vec_addr_o is 0x00, cur_lvl_o is idle and every pending flag is clear.
- R11: An acknowledge while irq_o is low changes neither cur_lvl_o nor any pending flag.
- R12: When an accepted acknowledge and a return pulse fall in the same cycle, cur_lvl_o becomes the acknowledged vector's level and the stack is left unchanged.
- R13: cur_lvl_o encodes idle as 0, low as 1, high as 2 and top as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 10 | Raw request per vector |
| edge_i | input | 10 | 1: sticky edge-type pending, 0: level-type |
| en_i | input | 10 | Per-vector enable |
| hi_i | input | 10 | Level select, 1 picks the vector's higher level |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Registered interrupt request |
| vec_addr_o | output | 8 | Address of the presented vector |
| cur_lvl_o | output | 2 | Level currently in service |

## Verification
Two events can collide in one cycle, and each collision is driven on purpose. In the first, an acknowledge arrives in the same cycle as a fresh request on the vector being acknowledged. The bench then expects that vector to be presented again once the level is restored. In the second, an acknowledge arrives together with a return pulse. The bench expects the new level to be taken without a net push, and checks this with a single later return that must reach idle. A behavioural model with a queue-based stack is compared with irq_o, vec_addr_o and cur_lvl_o on every cycle, so the timing of each collision is checked as well as the end state.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_IDLE = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_HIGH = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NUM_VEC = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] req_i,
  input  logic [NUM_VEC-1:0] edge_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] pend_o
);
  logic [NUM_VEC-1:0] pend_q;

  // edge-type bits are sticky until acknowledged; a new request beats the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= req_i | (edge_i & pend_q & ~clr_i);
  end

  assign pend_o = pend_q;

  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i[0] && pend_q[0] && !clr_i[0]) |=> pend_q[0]); // R8
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_level_pkg::*;
#(
  parameter int NUM_VEC     = 10,
  parameter int NUM_TOP_VEC = 2,
  localparam int IW         = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] pend_i,
  input  logic [NUM_VEC-1:0] en_i,
  input  logic [NUM_VEC-1:0] hi_i,
  input  lvl_t               cur_i,
  output logic               valid_o,
  output logic [IW-1:0]      idx_o,
  output lvl_t               lvl_o
);
  lvl_t               vlvl [NUM_VEC];
  logic [NUM_VEC-1:0] elig;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    if (g < NUM_TOP_VEC) begin : g_top
      assign vlvl[g] = hi_i[g] ? LVL_TOP : LVL_LOW;
    end else begin : g_mid
      assign vlvl[g] = hi_i[g] ? LVL_HIGH : LVL_LOW;
    end
    assign elig[g] = pend_i[g] & en_i[g] & (vlvl[g] > cur_i);
  end

  // descending scan: higher level replaces, equal level lets the lower index replace
  always_comb begin
    lvl_o = LVL_IDLE;
    idx_o = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (elig[i] && (vlvl[i] >= lvl_o)) begin
        lvl_o = vlvl[i];
        idx_o = IW'(i);
      end
    end
    valid_o = (lvl_o != LVL_IDLE);
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
  import irq_level_pkg::*;
#(
  parameter int STACK_DEPTH = 3,
  localparam int DW         = $clog2(STACK_DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  lvl_t new_lvl_i,
  output lvl_t cur_o
);
  lvl_t          stk_q [STACK_DEPTH];
  logic [DW-1:0] depth_q;
  lvl_t          cur_q;
  logic          pop_ok;

  assign pop_ok = pop_i && (depth_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= LVL_IDLE;
      depth_q <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) stk_q[i] <= LVL_IDLE;
    end else if (push_i) begin
      cur_q <= new_lvl_i;
      // push plus pop in one cycle nets out: stack untouched
      if (!pop_ok) begin
        stk_q[depth_q] <= cur_q;
        depth_q        <= depth_q + DW'(1);
      end
    end else if (pop_ok) begin
      cur_q   <= stk_q[depth_q - DW'(1)];
      depth_q <= depth_q - DW'(1);
    end
  end

  assign cur_o = cur_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && !pop_ok && (depth_q == DW'(STACK_DEPTH)))); // R6
  AST_CUR_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (cur_q > $past(cur_q))); // R6
  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && (depth_q == '0)) |=> $stable(cur_q)); // R7
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_level_pkg::*;
#(
  parameter int NUM_VEC     = 10,
  parameter int NUM_TOP_VEC = 2,
  parameter int STACK_DEPTH = 3,
  parameter int ADDR_W      = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] req_i,
  input  logic [NUM_VEC-1:0] edge_i,
  input  logic [NUM_VEC-1:0] en_i,
  input  logic [NUM_VEC-1:0] hi_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic [1:0]         cur_lvl_o
);
  localparam int IW = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0] pend, clr;
  logic               arb_valid;
  logic [IW-1:0]      arb_idx;
  lvl_t               arb_lvl;
  lvl_t               cur_lvl;
  logic               irq_q;
  logic [IW-1:0]      idx_q;
  lvl_t               lvl_q;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               acc;

  assign acc    = ack_i & irq_q;
  assign clr    = acc ? (NUM_VEC'(1) << idx_q) : '0;
  assign addr_d = ADDR_W'(VEC_BASE) + ADDR_W'(arb_idx) * ADDR_W'(VEC_STEP);

  irq_pend #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk_i, .rst_ni, .req_i, .edge_i, .clr_i(clr), .pend_o(pend)
  );

  irq_arb #(.NUM_VEC(NUM_VEC), .NUM_TOP_VEC(NUM_TOP_VEC)) u_arb (
    .pend_i(pend), .en_i, .hi_i, .cur_i(cur_lvl),
    .valid_o(arb_valid), .idx_o(arb_idx), .lvl_o(arb_lvl)
  );

  irq_nest #(.STACK_DEPTH(STACK_DEPTH)) u_nest (
    .clk_i, .rst_ni, .push_i(acc), .pop_i(reti_i), .new_lvl_i(lvl_q), .cur_o(cur_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      idx_q  <= '0;
      lvl_q  <= LVL_IDLE;
      addr_q <= '0;
    end else if (acc) begin
      irq_q <= 1'b0;  // state is stale this cycle; re-arbitrate next
    end else begin
      irq_q <= arb_valid;
      if (arb_valid) begin
        idx_q  <= arb_idx;
        lvl_q  <= arb_lvl;
        addr_q <= addr_d;
      end
    end
  end

  assign irq_o      = irq_q;
  assign vec_addr_o = addr_q;
  assign cur_lvl_o  = cur_lvl;

  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !irq_q); // R6
  AST_ABOVE_CUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (lvl_q > cur_lvl)); // R5
endmodule

// File: tb/irq_level_ctrl_tb.sv
module irq_level_ctrl_tb;
  localparam int NV = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NV-1:0] req_i = '0, edge_i = '0, en_i = '0, hi_i = '0;
  logic          ack_i = 1'b0, reti_i = 1'b0;
  logic          irq_o;
  logic [7:0]    vec_addr_o;
  logic [1:0]    cur_lvl_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_level_ctrl u_dut (
    .clk_i, .rst_ni, .req_i, .edge_i, .en_i, .hi_i,
    .ack_i, .reti_i, .irq_o, .vec_addr_o, .cur_lvl_o
  );

  // behavioural reference
  logic [NV-1:0] m_pend;
  int            m_stack[$];
  int            m_cur, m_idx, m_lvl, m_addr;
  bit            m_irq;

  function automatic int vlvl(int v);
    if (!hi_i[v]) return 1;
    return (v < 2) ? 3 : 2;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pend = '0; m_stack.delete(); m_cur = 0; m_idx = 0; m_lvl = 0; m_addr = 0; m_irq = 0;
    end else begin
      int best, bl;
      bit acc;
      best = -1; bl = 0;
      for (int v = 0; v < NV; v++)
        if (m_pend[v] && en_i[v] && vlvl(v) > m_cur && vlvl(v) > bl) begin
          best = v; bl = vlvl(v);
        end
      acc = ack_i && m_irq;
      for (int v = 0; v < NV; v++)
        if (edge_i[v]) m_pend[v] = req_i[v] || (m_pend[v] && !(acc && v == m_idx));
        else           m_pend[v] = req_i[v];
      if (acc) begin
        if (!(reti_i && m_stack.size() > 0)) m_stack.push_back(m_cur);
        m_cur = m_lvl;
        m_irq = 0;
      end else begin
        if (reti_i && m_stack.size() > 0) m_cur = m_stack.pop_back();
        m_irq = (best >= 0);
        if (best >= 0) begin m_idx = best; m_lvl = bl; m_addr = 3 + 8 * best; end
      end
    end
  end

  // cycle compare against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (irq_o !== m_irq) begin
        errors++; $display("FAIL R9 model irq: actual %0d expected %0d", irq_o, m_irq);
      end
      checks++;
      if (int'(cur_lvl_o) != m_cur) begin
        errors++; $display("FAIL R6 model level: actual %0d expected %0d", cur_lvl_o, m_cur);
      end
      if (m_irq) begin
        checks++;
        if (int'(vec_addr_o) != m_addr) begin
          errors++; $display("FAIL R1 model addr: actual %0h expected %0h", vec_addr_o, m_addr);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_ack();
    ack_i = 1'b1; tick(1); ack_i = 1'b0;
  endtask

  task automatic do_reti();
    reti_i = 1'b1; tick(1); reti_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    chk(irq_o, 0, "R10 irq"); chk(vec_addr_o, 0, "R10 addr"); chk(cur_lvl_o, 0, "R10 level");
    rst_ni = 1'b1;
    edge_i = '1; en_i = '1; hi_i = '0;
    tick(1);

    // R9 latency and R1 address
    req_i = NV'(1) << 5; tick(1); req_i = '0;
    chk(irq_o, 0, "R9 one edge");
    tick(1);
    chk(irq_o, 1, "R9 two edges"); chk(vec_addr_o, 8'h2B, "R1 vector 5");

    // R4 same level, lowest index
    req_i = (NV'(1) << 2) | (NV'(1) << 7); tick(1); req_i = '0; tick(2);
    chk(vec_addr_o, 8'h13, "R4 lowest index");

    // R6 acknowledge, R13 encoding, R5 block at same level
    do_ack();
    chk(cur_lvl_o, 1, "R13 low level"); chk(irq_o, 0, "R6 drop after ack");
    tick(3);
    chk(irq_o, 0, "R5 blocked at low");

    // R3 higher level beats lower index
    hi_i[7] = 1'b1; tick(2);
    chk(irq_o, 1, "R3 high present"); chk(vec_addr_o, 8'h3B, "R3 high wins");
    do_ack();
    chk(cur_lvl_o, 2, "R6 high in service");

    // R2 top level on index 0
    hi_i[0] = 1'b1; req_i = NV'(1); tick(1); req_i = '0; tick(2);
    chk(vec_addr_o, 8'h03, "R2 top vector");
    do_ack();
    chk(cur_lvl_o, 3, "R13 top level");

    // R7 unwind
    do_reti(); chk(cur_lvl_o, 2, "R7 pop to high");
    do_reti(); chk(cur_lvl_o, 1, "R7 pop to low");
    do_reti(); chk(cur_lvl_o, 0, "R7 pop to idle");
    tick(2);
    chk(irq_o, 1, "R5 released"); chk(vec_addr_o, 8'h2B, "R5 waiting vector");
    do_reti(); chk(cur_lvl_o, 0, "R7 empty pop");

    // R5 enable mask, R11 ack while low
    en_i[5] = 1'b0; tick(2);
    chk(irq_o, 0, "R5 disabled");
    do_ack(); chk(cur_lvl_o, 0, "R11 ignored ack");
    en_i[5] = 1'b1; tick(2);
    chk(irq_o, 1, "R11 pending kept");

    // R8 clear on ack
    do_ack(); do_reti(); tick(3);
    chk(irq_o, 0, "R8 edge cleared");

    // R8 set wins over clear
    req_i = NV'(1) << 5; tick(1); req_i = '0; tick(2);
    ack_i = 1'b1; req_i = NV'(1) << 5; tick(1); ack_i = 1'b0; req_i = '0;
    chk(cur_lvl_o, 1, "R8 accepted");
    do_reti(); tick(2);
    chk(irq_o, 1, "R8 set wins"); chk(vec_addr_o, 8'h2B, "R8 same vector");
    do_ack(); do_reti(); tick(2);

    // R8 level-type vector
    edge_i[3] = 1'b0; req_i[3] = 1'b1; tick(3);
    chk(vec_addr_o, 8'h1B, "R8 level vector");
    do_ack(); chk(cur_lvl_o, 1, "R8 level ack");
    do_reti(); tick(2);
    chk(irq_o, 1, "R8 level not cleared"); chk(vec_addr_o, 8'h1B, "R8 level addr");

    // R12 ack with return
    do_ack();
    hi_i[4] = 1'b1; req_i[4] = 1'b1; tick(1); req_i[4] = 1'b0; tick(2);
    chk(vec_addr_o, 8'h23, "R12 high presented");
    ack_i = 1'b1; reti_i = 1'b1; tick(1); ack_i = 1'b0; reti_i = 1'b0;
    chk(cur_lvl_o, 2, "R12 new level");
    hi_i[1] = 1'b1; hi_i[2] = 1'b1;
    req_i[1] = 1'b1; req_i[2] = 1'b1; tick(1); req_i[1] = 1'b0; req_i[2] = 1'b0; tick(2);
    chk(vec_addr_o, 8'h0B, "R2 top over high service");
    do_reti();
    chk(cur_lvl_o, 0, "R12 stack unchanged");
    req_i = '0;
    tick(3);
    finish_run();
  end
endmodule